// File: doc/BRIEF.md
# Sticky Fault Cause Register

This block records which supervisory event last pulled the system into reset. It holds one bit for each of five event sources: the manual reset button, the watchdog timeout, a low main supply, a low second rail and a low third rail. All bits come up as 0. Software arms monitoring by writing ones. A failing source drops its own bit to 0, and the bit stays at 0 until software writes it again.

The block sits behind a serial slave interface that has already decoded the bus traffic. It sees a write strobe with an address and a data byte, and a read strobe with an address. It returns the read byte one clock later. A write-protect input blocks every write. The event inputs are levels from asynchronous comparators and timers, so they pass through a parameterised synchronizer before they act on the bits.

Top module: `fault_cause_reg`

## Requirements
- R1: A synchronous reset brings all five cause bits to 0, so a read of address 0xFF afterwards returns 0x00.
- R2: A write to address 0xFF while write-protect is low loads the five cause bits from data bits [4:0]. A 1 arms the bit and a 0 clears it. Data bits [7:5] are discarded.
- R3: An event input that is asserted for one clock or longer clears its cause bit within SYNC_STAGES+1 clocks. The bit stays at 0 after the event drops, until software writes it again.
- R4: Bit positions in the byte are: bit0 third rail low, bit1 second rail low, bit2 main supply low, bit3 watchdog timeout, bit4 manual reset. The event input vector uses the same indices.
- R5: When a fault and a write reach the same bit in the same cycle, the fault wins. While an event is held asserted, writes cannot set its bit.
- R6: While write-protect is high, no write changes any bit.
- R7: A write to any address other than 0xFF changes no bit.
- R8: A read strobe at address 0xFF presents {3'b000, cause bits} on the read data one clock later. Bits [7:5] always read 0.
- R9: A read strobe at any other address presents 0x00 and leaves the cause bits unchanged.
- R10: While the read strobe is low, the read data holds its last value, even if the cause bits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 5 | Fault event levels, indexed as in R4 |
| wp_i | input | 1 | Write protect, high blocks all writes |
| wr_en_i | input | 1 | Write strobe from the decoded bus |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe from the decoded bus |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The hardest case to reach is a write and a fault landing on the same bit together. From the ports that case is hidden behind the synchronizer delay. The stimulus holds the second-rail event asserted long enough to cover the synchronizer latency, and then issues an arming write of 0x1F. Every write cycle therefore coincides with an active fault on that bit, and the read must show bit1 still at 0. The stimulus then releases the event and writes again, to show that the bit can still be armed.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  // Number of supervised event sources; bit order is fixed by software.
  localparam int NUM_SRC = 5;
endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
          st[0] <= d_i;
          for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
      end
      assign q_o = st[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fcr_cell.sv
module fcr_cell (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)          q_o <= 1'b0;
    else if (fault_i) q_o <= 1'b0;   // fault has priority over software
    else if (wr_i)    q_o <= wr_bit_i;
  end

  // R1: reset clears the bit
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> !q_o);
  // R3 / R5: a synchronized fault always leaves the bit at 0
  a_r5_fault_wins: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> !q_o);
  // R2: an unopposed write loads the bit
  a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !fault_i) |=> (q_o == $past(wr_bit_i)));
  // R3: with no fault and no write the bit is sticky
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !fault_i) |=> $stable(q_o));
endmodule

// File: rtl/fcr_read.sv
module fcr_read #(
  parameter int               AW       = 8,
  parameter int               DW       = 8,
  parameter int               NSRC     = 5,
  parameter logic [AW-1:0]    REG_ADDR = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic [NSRC-1:0] bits_i,
  output logic [DW-1:0]   rd_data_o
);
  localparam int PAD = DW - NSRC;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (rd_addr_i == REG_ADDR) rd_data_o <= {{PAD{1'b0}}, bits_i};
      else                       rd_data_o <= '0;
    end
  end

  // R9: reads of other addresses return zero
  a_r9_other_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i != REG_ADDR) |=> (rd_data_o == '0));
  // R8: unused upper bits never set
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[DW-1:NSRC] == '0);
  // R10: output holds without a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/fault_cause_reg.sv
module fault_cause_reg #(
  parameter int            ADDR_W      = 8,
  parameter int            DATA_W      = 8,
  parameter logic [7:0]    REG_ADDR    = 8'hFF,
  parameter int            SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [fcr_pkg::NUM_SRC-1:0] evt_i,
  input  logic                        wp_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o
);
  localparam int NSRC = fcr_pkg::NUM_SRC;
  localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(REG_ADDR);

  logic [NSRC-1:0] fault_s;
  logic [NSRC-1:0] bits;
  logic            wr_hit;

  fcr_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(evt_i), .q_o(fault_s)
  );

  assign wr_hit = wr_en_i && !wp_i && (wr_addr_i == ADDR);

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_cell
      fcr_cell u_cell (
        .clk(clk), .rst(rst),
        .fault_i(fault_s[g]),
        .wr_i(wr_hit),
        .wr_bit_i(wr_data_i[g]),
        .q_o(bits[g])
      );
    end
  endgenerate

  fcr_read #(.AW(ADDR_W), .DW(DATA_W), .NSRC(NSRC), .REG_ADDR(ADDR)) u_read (
    .clk(clk), .rst(rst),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .bits_i(bits), .rd_data_o(rd_data_o)
  );

  // R6: under write protect no bit can rise
  a_r6_wp_no_rise: assert property (@(posedge clk) disable iff (rst)
    wp_i |=> ((bits & ~$past(bits)) == '0));
  // R7: writes elsewhere never raise a bit
  a_r7_addr_no_rise: assert property (@(posedge clk) disable iff (rst)
    (wr_addr_i != ADDR) |=> ((bits & ~$past(bits)) == '0));
  // R9: a read strobe never raises a bit
  a_r9_read_no_rise: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> ((bits & ~$past(bits)) == '0));
endmodule

// File: tb/fault_cause_reg_test.sv
module fault_cause_reg_test;
  localparam int CLK_P = 10;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] evt = '0;
  logic       wp = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fault_cause_reg uut (
    .clk(clk), .rst(rst), .evt_i(evt), .wp_i(wp),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // Monitor: pop expected item after each completed read
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R8: unexpected read result 0x%02h expected none", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evt[idx] = 1'b1;
    @(negedge clk);
    evt[idx] = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(8'hFF, 8'h00, "R1 reset state");
    wr(8'hFF, 8'hFF);
    rd(8'hFF, 8'h1F, "R2/R8 arm, upper bits zero");
    pulse(2);
    rd(8'hFF, 8'h1B, "R3/R4 main supply bit2");
    repeat (6) @(negedge clk);
    rd(8'hFF, 8'h1B, "R3 sticky after event gone");
    pulse(4);
    rd(8'hFF, 8'h0B, "R4 manual reset bit4");
    pulse(0);
    rd(8'hFF, 8'h0A, "R4 third rail bit0");
    pulse(3);
    rd(8'hFF, 8'h02, "R4 watchdog bit3");
    wr(8'hFF, 8'h1F);
    rd(8'hFF, 8'h1F, "R2 rewrite arms");
    wp = 1'b1;
    wr(8'hFF, 8'h00);
    rd(8'hFF, 8'h1F, "R6 write protect");
    wp = 1'b0;
    wr(8'h10, 8'h00);
    rd(8'hFF, 8'h1F, "R7 other write address");
    rd(8'h00, 8'h00, "R9 other read address");
    rd(8'hFF, 8'h1F, "R9 register unchanged");
    // R5: hold second rail fault across an arming write
    @(negedge clk); evt[1] = 1'b1;
    repeat (SETTLE) @(negedge clk);
    wr(8'hFF, 8'h1F);
    rd(8'hFF, 8'h1D, "R5 held fault beats write");
    @(negedge clk); evt[1] = 1'b0;
    repeat (SETTLE) @(negedge clk);
    wr(8'hFF, 8'h1F);
    rd(8'hFF, 8'h1F, "R5 rearm after release");
    // R10: read data holds while strobe is low
    wr(8'hFF, 8'h00);
    repeat (2) @(negedge clk);
    chk(rd_data, 8'h1F, "R10 hold without strobe");
    rd(8'hFF, 8'h00, "R2 write zero clears");
    wr(8'hFF, 8'h15);
    rd(8'hFF, 8'h15, "R2 partial pattern");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'hFF, 8'h00, "R1 reset mid-run");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; fails++;
      $display("FAIL R8: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end
endmodule